// File: doc/BRIEF.md
# Multi-window event and semaphore file

This block is a shared synchronisation store: 256 single-bit events and 256 unsigned 32-bit counting semaphores. One bus slave port reaches the same semaphore counters through four address windows. One window reads a counter. One overwrites it. One adds the written value to it, and one subtracts the written value from it. A producer signals by writing to the add window, and a consumer releases by writing to the subtract window. A requester that must wait selects a counter and a threshold and watches `ge_ok`. This output rises once the counter is greater than or equal to the threshold.

A second input stream lets a DMA engine post increments. It uses a valid/ready handshake. The DMA stream has lower priority than the bus:
- When a bus overwrite targets the same counter in the same cycle, `dma_ready` drops and the DMA beat must be held. A stalled beat must keep its index and delta stable until it is accepted.
- When a bus add or subtract targets the same counter as an accepted DMA beat, both changes are merged into one update.

The bus port never stalls. A read answers with `bus_rvalid` and `bus_rdata` exactly one cycle after the request.

Top module: `evsem_file`

## Requirements
- R1: After reset every counter and every event reads 0, `wrap_seen` is 0 and `bus_rvalid` is 0.
- R2: A bus write to the overwrite window (byte offset 0x1400 + 4·index) loads the counter with `bus_wdata`. A bus read of the read window (0x1000 + 4·index) returns the counter one cycle after the request.
- R3: A bus write to the add window (0x1800 + 4·index) adds `bus_wdata`, and a write to the subtract window (0x1C00 + 4·index) subtracts it. Both wrap modulo 2^32.
- R4: Reads of the overwrite, add or subtract windows return 0 with `bus_rvalid` high. Writes to the read window leave the counter unchanged.
- R5: Bus writes to the overwrite, add or subtract windows for indices 0, 1 and 2 are rejected, and those counters keep their values.
- R6: An accepted DMA beat (`dma_valid` and `dma_ready` high at a clock edge) adds `dma_delta` to counter `dma_idx`. Indices 0 to 2 accept DMA beats.
- R7: A bus add or subtract and an accepted DMA beat that target the same counter in one cycle are both applied.
- R8: `dma_ready` is low in any cycle where a bus overwrite writes a non-reserved index equal to `dma_idx`. Otherwise it is high. A held beat is applied once accepted.
- R9: `wrap_seen` goes high on any update whose unbounded result lies outside 0 to 2^32−1, and stays high until reset.
- R10: `ge_ok` is combinationally high exactly when counter `wait_idx` is greater than or equal to `wait_thr`, compared as unsigned values.
- R11: Event `i` sits at byte offset 4·i (window 0x0000–0x03FF). A write sets the event to `bus_wdata[0]`, and a read returns the event in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after the read) |
| bus_rdata | output | 32 | Read data |
| dma_valid | input | 1 | DMA increment beat offered |
| dma_ready | output | 1 | DMA beat accepted this cycle |
| dma_idx | input | 8 | DMA target semaphore |
| dma_delta | input | 32 | DMA increment amount |
| wait_idx | input | 8 | Semaphore watched by the compare |
| wait_thr | input | 32 | Compare threshold |
| ge_ok | output | 1 | Counter at or above threshold |
| wrap_seen | output | 1 | Sticky wrap flag |

## Verification
Two functions can land on the same counter in the same cycle: a bus update and a DMA increment. The bench drives a bus add or subtract together with a DMA beat for the same index, then reads the counter back. The value read must carry both changes. It also drives a bus overwrite against a DMA beat for the same index. In that case `dma_ready` must be low in that cycle, and the held beat must appear on top of the overwritten value one cycle later.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
  typedef enum logic [2:0] {
    WIN_EVT  = 3'd0,
    WIN_RD   = 3'd1,
    WIN_SET  = 3'd2,
    WIN_ADD  = 3'd3,
    WIN_SUB  = 3'd4,
    WIN_NONE = 3'd5
  } win_e;

  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned RESERVED = 3;
endpackage

// File: rtl/evsem_decode.sv
module evsem_decode
  import evsem_pkg::*;
#(
  parameter int unsigned IW = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IW-1:0]     idx,
  output logic              reserved
);
  // Bits 12:10 choose the window; the index field sits above the byte lane.
  always_comb begin
    unique case (addr[12:10])
      3'd0:    win = WIN_EVT;
      3'd4:    win = WIN_RD;
      3'd5:    win = WIN_SET;
      3'd6:    win = WIN_ADD;
      3'd7:    win = WIN_SUB;
      default: win = WIN_NONE;
    endcase
    if (addr[1:0] != 2'b00) win = WIN_NONE;
  end

  assign idx      = addr[IW+1:2];
  assign reserved = ({{(32-IW){1'b0}}, idx} < RESERVED);
endmodule

// File: rtl/evsem_combine.sv
module evsem_combine
  import evsem_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  win_e          op,
  input  logic [DW-1:0] wdata,
  input  logic          dma_en,
  input  logic [DW-1:0] dma_delta,
  output logic [DW-1:0] new_val,
  output logic          wrapped
);
  localparam int unsigned XW = DW + 3;

  logic [XW-1:0] pos, neg, diff;

  always_comb begin
    pos = {3'b000, old_val};
    neg = '0;
    if (op == WIN_ADD) pos = pos + {3'b000, wdata};
    if (op == WIN_SUB) neg = {3'b000, wdata};
    if (dma_en)        pos = pos + {3'b000, dma_delta};
    diff = pos - neg;
    if (op == WIN_SET) begin
      new_val = wdata;
      wrapped = 1'b0;
    end else begin
      new_val = diff[DW-1:0];
      wrapped = (pos < neg) || (diff[XW-1:DW] != '0);
    end
  end
endmodule

// File: rtl/evsem_events.sv
module evsem_events #(
  parameter int unsigned NEVT = 256,
  parameter int unsigned IW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic          wbit,
  output logic          rbit
);
  logic [NEVT-1:0] flags;

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)                         flags[g] <= 1'b0;
      else if (wr_en && idx == IW'(g))    flags[g] <= wbit;
    end
  end

  assign rbit = flags[idx];
endmodule

// File: rtl/evsem_file.sv
module evsem_file
  import evsem_pkg::*;
#(
  parameter int unsigned NSEM = 256,
  parameter int unsigned NEVT = 256,
  parameter int unsigned DW   = 32,
  parameter int unsigned IW   = $clog2(NSEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [IW-1:0]     dma_idx,
  input  logic [DW-1:0]     dma_delta,
  input  logic [IW-1:0]     wait_idx,
  input  logic [DW-1:0]     wait_thr,
  output logic              ge_ok,
  output logic              wrap_seen
);
  win_e          win;
  logic [IW-1:0] bidx;
  logic          brsv;

  evsem_decode #(.IW(IW)) u_dec (
    .addr(bus_addr), .win(win), .idx(bidx), .reserved(brsv)
  );

  logic [DW-1:0] sem [NSEM];

  // A bus write that lands on a counter (reserved indices are refused).
  logic bus_hit, set_hit, dma_fire, same;
  assign bus_hit  = bus_valid && bus_write && !brsv &&
                    (win == WIN_SET || win == WIN_ADD || win == WIN_SUB);
  assign set_hit  = bus_hit && (win == WIN_SET);
  assign dma_ready = !(set_hit && bidx == dma_idx);
  assign dma_fire = dma_valid && dma_ready;
  assign same     = bus_hit && dma_fire && (bidx == dma_idx);

  logic [DW-1:0] bus_next, dma_next;
  logic          bus_wrap, dma_wrap;

  evsem_combine #(.DW(DW)) u_bus_upd (
    .old_val(sem[bidx]), .op(win), .wdata(bus_wdata),
    .dma_en(same), .dma_delta(dma_delta),
    .new_val(bus_next), .wrapped(bus_wrap)
  );

  evsem_combine #(.DW(DW)) u_dma_upd (
    .old_val(sem[dma_idx]), .op(WIN_NONE), .wdata('0),
    .dma_en(1'b1), .dma_delta(dma_delta),
    .new_val(dma_next), .wrapped(dma_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEM; i++) sem[i] <= '0;
      wrap_seen <= 1'b0;
    end else begin
      if (bus_hit)          sem[bidx]    <= bus_next;
      if (dma_fire && !same) sem[dma_idx] <= dma_next;
      if ((bus_hit && bus_wrap) || (dma_fire && !same && dma_wrap))
        wrap_seen <= 1'b1;
    end
  end

  logic evt_bit;
  evsem_events #(.NEVT(NEVT), .IW(IW)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_valid && bus_write && win == WIN_EVT),
    .idx(bidx), .wbit(bus_wdata[0]), .rbit(evt_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) begin
        unique case (win)
          WIN_RD:  bus_rdata <= sem[bidx];
          WIN_EVT: bus_rdata <= {{(DW-1){1'b0}}, evt_bit};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assign ge_ok = (sem[wait_idx] >= wait_thr);
endmodule

// File: rtl/evsem_file_chk.sv
module evsem_file_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [12:0]   bus_addr,
  input logic          bus_rvalid,
  input logic [DW-1:0] bus_rdata,
  input logic          dma_ready,
  input logic [IW-1:0] dma_idx,
  input logic          wrap_seen
);
  logic rd_req, wo_rd, set_same;
  assign rd_req   = bus_valid && !bus_write;
  assign wo_rd    = rd_req && bus_addr[12] && (bus_addr[11:10] != 2'b00) &&
                    (bus_addr[1:0] == 2'b00);
  assign set_same = bus_valid && bus_write && bus_addr[12:10] == 3'd5 &&
                    bus_addr[1:0] == 2'b00 && bus_addr[IW+1:2] >= 3 &&
                    bus_addr[IW+1:2] == dma_idx;

  assert_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  assert_no_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
  assert_wo_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wo_rd |=> (bus_rdata == '0));
  assert_dma_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_same |-> !dma_ready);
  assert_wrap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_seen |=> wrap_seen);
endmodule

bind evsem_file evsem_file_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .dma_ready(dma_ready), .dma_idx(dma_idx), .wrap_seen(wrap_seen)
);

// File: tb/evsem_file_test.sv
module evsem_file_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        dma_valid = 1'b0;
  logic        dma_ready;
  logic [7:0]  dma_idx = '0;
  logic [31:0] dma_delta = '0;
  logic [7:0]  wait_idx = '0;
  logic [31:0] wait_thr = '0;
  logic        ge_ok, wrap_seen;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evsem_file uut (.*);

  typedef struct packed {
    logic        wr;
    logic [12:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'h1414, 32'd100,        32'd0,        8'd2},  // R2 set idx5
    '{1'b0, 13'h1014, 32'd0,          32'd100,      8'd2},
    '{1'b1, 13'h1814, 32'd23,         32'd0,        8'd3},  // R3 add
    '{1'b0, 13'h1014, 32'd0,          32'd123,      8'd3},
    '{1'b1, 13'h1C14, 32'd3,          32'd0,        8'd3},  // R3 subtract
    '{1'b0, 13'h1014, 32'd0,          32'd120,      8'd3},
    '{1'b1, 13'h1014, 32'd999,        32'd0,        8'd4},  // R4 write to read window
    '{1'b0, 13'h1014, 32'd0,          32'd120,      8'd4},
    '{1'b0, 13'h1414, 32'd0,          32'd0,        8'd4},  // R4 write-only reads 0
    '{1'b0, 13'h1814, 32'd0,          32'd0,        8'd4},
    '{1'b0, 13'h1C14, 32'd0,          32'd0,        8'd4},
    '{1'b1, 13'h1404, 32'd77,         32'd0,        8'd5},  // R5 reserved idx1
    '{1'b0, 13'h1004, 32'd0,          32'd0,        8'd5},
    '{1'b1, 13'h1808, 32'd5,          32'd0,        8'd5},  // R5 reserved idx2
    '{1'b0, 13'h1008, 32'd0,          32'd0,        8'd5},
    '{1'b1, 13'h000C, 32'd1,          32'd0,        8'd11}, // R11 event 3
    '{1'b0, 13'h000C, 32'd0,          32'd1,        8'd11},
    '{1'b0, 13'h0010, 32'd0,          32'd0,        8'd11},
    '{1'b1, 13'h17FC, 32'hFFFF_FFFF,  32'd0,        8'd2}   // R2 set idx255
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, input string req, input logic [31:0] exp);
    bus_op(1'b0, 13'h1000 + {idx, 2'b00}, 32'd0);
    check(req, {31'd0, bus_rvalid}, 32'd1);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
    check("R1 wrap", {31'd0, wrap_seen}, 32'd0);
    rd(8'd10, "R1 counter", 32'd0);
    bus_op(1'b0, 13'h0028, 32'd0);
    check("R1 event", bus_rdata, 32'd0);
    wait_idx = 8'd10; wait_thr = 32'd0; #1;
    check("R10 ge at 0", {31'd0, ge_ok}, 32'd1);
    wait_thr = 32'd1; #1;
    check("R10 below", {31'd0, ge_ok}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i].wr, VEC[i].addr, VEC[i].data);
      if (!VEC[i].wr) begin
        checks++;
        if (bus_rdata !== VEC[i].exp || bus_rvalid !== 1'b1) begin
          errors++;
          $display("FAIL R%0d vec%0d actual=%h expected=%h", VEC[i].req, i, bus_rdata, VEC[i].exp);
        end
      end
    end
    rd(8'd255, "R2 idx255", 32'hFFFF_FFFF);
    check("R9 no wrap yet", {31'd0, wrap_seen}, 32'd0);

    // R3 / R9 wrap on add
    bus_op(1'b1, 13'h141C, 32'hFFFF_FFFE);
    bus_op(1'b1, 13'h181C, 32'd3);
    rd(8'd7, "R3 add wraps", 32'd1);
    check("R9 wrap set", {31'd0, wrap_seen}, 32'd1);
    // subtract wrap
    bus_op(1'b1, 13'h1420, 32'd1);
    bus_op(1'b1, 13'h1C20, 32'd2);
    rd(8'd8, "R3 sub wraps", 32'hFFFF_FFFF);
    check("R9 sticky", {31'd0, wrap_seen}, 32'd1);

    // R6 DMA into reserved index 0
    @(negedge clk);
    dma_valid = 1'b1; dma_idx = 8'd0; dma_delta = 32'd9; #1;
    check("R6 ready", {31'd0, dma_ready}, 32'd1);
    @(negedge clk);
    dma_valid = 1'b0;
    rd(8'd0, "R6 dma add", 32'd9);

    // R7 bus add + DMA same counter
    bus_op(1'b1, 13'h1450, 32'd10);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 13'h1850; bus_wdata = 32'd5;
    dma_valid = 1'b1; dma_idx = 8'd20; dma_delta = 32'd7;
    @(negedge clk);
    bus_valid = 1'b0; dma_valid = 1'b0;
    rd(8'd20, "R7 add+dma", 32'd22);
    // R7 bus subtract + DMA same counter
    bus_op(1'b1, 13'h1454, 32'd10);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 13'h1C54; bus_wdata = 32'd4;
    dma_valid = 1'b1; dma_idx = 8'd21; dma_delta = 32'd1;
    @(negedge clk);
    bus_valid = 1'b0; dma_valid = 1'b0;
    rd(8'd21, "R7 sub+dma", 32'd7);

    // R8 overwrite stalls DMA on same index
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 13'h1458; bus_wdata = 32'd50;
    dma_valid = 1'b1; dma_idx = 8'd22; dma_delta = 32'd3; #1;
    check("R8 stall", {31'd0, dma_ready}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b0; #1;
    check("R8 release", {31'd0, dma_ready}, 32'd1);
    @(negedge clk);
    dma_valid = 1'b0;
    rd(8'd22, "R8 held beat", 32'd53);

    // R10 compare
    wait_idx = 8'd22; wait_thr = 32'd53; #1;
    check("R10 equal", {31'd0, ge_ok}, 32'd1);
    wait_thr = 32'd54; #1;
    check("R10 above", {31'd0, ge_ok}, 32'd0);
    wait_thr = 32'h8000_0000; #1;
    check("R10 large thr", {31'd0, ge_ok}, 32'd0);
    wait_idx = 8'd8; #1;
    check("R10 unsigned", {31'd0, ge_ok}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule